// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small system between four power modes. In normal mode the core clock and the peripheral clock both run. In idle mode only the core clock stops. In suspend mode both clocks stop. In shutdown the internal supplies are cut off, and the pins keep their last driven state. Software asks for a mode by writing request bits through a simple register write port. Each low-power mode has its own entry condition and its own set of wake sources.

Idle ends on any enabled interrupt request. Suspend ends only on a bus-activity strobe. Shutdown ends only on a pin reset or a power-on reset. The block samples every wake input through a two-stage synchroniser before it acts on it. All outputs are decoded from registered state, so they change only on a clock edge.

Top module: `pwr_mode_seq`

## Requirements
- R1: After power-on reset (`rst_n` low) the block is in normal mode. `core_clk_en`=1, `periph_clk_en`=1, `reg_off_req`=0, `pin_hold`=0 and `vreg5_en`=1. The power register (address 0) reads 0x00, the oscillator register (address 1) reads 0x00 and the regulator register (address 2) reads 0x02.
- R2: In normal mode, a write to address 0 with bit 0 set enters idle on that clock edge. The block then shows `core_clk_en`=0 and `periph_clk_en`=1, and address 0 bit 0 reads 1.
- R3: Idle returns to normal on the third rising edge after any bit of `irq_pend` goes high. Address 0 bit 0 then reads 0. `usb_act` has no effect in idle.
- R4: In normal mode, a write to address 1 with bit 0 set enters suspend only when `clk_src` is 2'b00. Otherwise the request is ignored and the sticky error flag (address 1 bit 7) is set. A write to address 1 with bit 7 set clears that flag.
- R5: Suspend shows both clock enables at 0 and address 1 bit 0 reads 1. It returns to normal on the third rising edge after `usb_act` rises, and bit 0 then reads 0. `irq_pend` has no effect in suspend.
- R6: A write to address 0 with bit 1 set enters shutdown only if the arm bit (address 2 bit 0) was already set. A write of bit 1 without the arm bit is ignored. Shutdown shows `reg_off_req`=1, `pin_hold`=1 and both clock enables at 0.
- R7: Shutdown is left only by `pin_rst`, which takes effect on the third rising edge after it rises and restores every register to its reset value, or by `rst_n`. `irq_pend` and `usb_act` have no effect in shutdown.
- R8: `vreg5_en` follows address 2 bit 1 (reset value 1) and keeps that value through shutdown.
- R9: Request writes made outside normal mode have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| clk_src | input | 2 | Current system clock source; 2'b00 is the internal high-frequency oscillator |
| irq_pend | input | NIRQ | Enabled interrupt requests, asynchronous |
| usb_act | input | 1 | Bus-activity strobe, asynchronous |
| pin_rst | input | 1 | Pin reset request, active high, asynchronous |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| reg_off_req | output | 1 | Request to shut down the internal regulator |
| pin_hold | output | 1 | Hold the pins at their last state |
| vreg5_en | output | 1 | 5 V regulator enable |

## Verification
A register write changes the mode and the outputs on the same rising edge that captures it. The bench therefore drives each write at a falling edge and checks the result at the very next falling edge. A wake input passes through two synchroniser flops and then the mode register, so it takes effect on the third rising edge after it rises. For each wake, the bench checks that the old mode still holds at the second falling edge and that the new mode appears at the third. For inputs that must be ignored, the bench holds them for four cycles and then reads both the outputs and the registers.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    M_NORM = 2'd0,
    M_IDLE = 2'd1,
    M_SUSP = 2'd2,
    M_SHUT = 2'd3
  } pmode_e;

  localparam int AW = 2;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_PWR = 2'd0;
  localparam logic [AW-1:0] A_OSC = 2'd1;
  localparam logic [AW-1:0] A_REG = 2'd2;

  localparam int B_IDLE = 0;
  localparam int B_STOP = 1;
  localparam int B_SUSP = 0;
  localparam int B_ERR  = 7;
  localparam int B_ARM  = 0;
  localparam int B_HV   = 1;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
#(
  parameter int          CSW    = 2,
  parameter logic [CSW-1:0] HF_SEL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [CSW-1:0] clk_src,
  input  logic           wake_irq,
  input  logic           wake_bus,
  input  logic           pin_rst_s,
  output pmode_e         mode_q,
  output logic           err_q,
  output logic           arm_q,
  output logic           hv_q
);
  pmode_e mode_d;
  logic   err_d, arm_d, hv_d;
  logic   unused_bits;

  assign unused_bits = ^wr_data[6:2];

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    arm_d  = arm_q;
    hv_d   = hv_q;
    if (pin_rst_s) begin
      mode_d = M_NORM;
      err_d  = 1'b0;
      arm_d  = 1'b0;
      hv_d   = 1'b1;
    end else begin
      unique case (mode_q)
        M_IDLE: if (wake_irq) mode_d = M_NORM;
        M_SUSP: if (wake_bus) mode_d = M_NORM;
        M_SHUT: mode_d = M_SHUT;
        default: begin
          if (wr_en) begin
            if (wr_addr == A_PWR) begin
              if (wr_data[B_STOP] && arm_q) mode_d = M_SHUT;
              else if (wr_data[B_IDLE])     mode_d = M_IDLE;
            end else if (wr_addr == A_OSC) begin
              if (wr_data[B_ERR]) err_d = 1'b0;
              if (wr_data[B_SUSP]) begin
                if (clk_src == HF_SEL) mode_d = M_SUSP;
                else                   err_d  = 1'b1;
              end
            end else if (wr_addr == A_REG) begin
              arm_d = wr_data[B_ARM];
              hv_d  = wr_data[B_HV];
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_NORM;
      err_q  <= 1'b0;
      arm_q  <= 1'b0;
      hv_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
      arm_q  <= arm_d;
      hv_q   <= hv_d;
    end
  end
endmodule

// File: rtl/pms_view.sv
module pms_view
  import pms_pkg::*;
(
  input  pmode_e         mode_q,
  input  logic           err_q,
  input  logic           arm_q,
  input  logic           hv_q,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           core_clk_en,
  output logic           periph_clk_en,
  output logic           reg_off_req,
  output logic           pin_hold,
  output logic           vreg5_en
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == A_PWR) begin
      rd_data[B_IDLE] = (mode_q == M_IDLE);
    end else if (rd_addr == A_OSC) begin
      rd_data[B_SUSP] = (mode_q == M_SUSP);
      rd_data[B_ERR]  = err_q;
    end else if (rd_addr == A_REG) begin
      rd_data[B_ARM]  = arm_q;
      rd_data[B_HV]   = hv_q;
    end
  end

  assign core_clk_en   = (mode_q == M_NORM);
  assign periph_clk_en = (mode_q == M_NORM) || (mode_q == M_IDLE);
  assign reg_off_req   = (mode_q == M_SHUT);
  assign pin_hold      = (mode_q == M_SHUT);
  assign vreg5_en      = hv_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NIRQ = 4,
  parameter int CSW  = 2,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [CSW-1:0]   clk_src,
  input  logic [NIRQ-1:0]  irq_pend,
  input  logic             usb_act,
  input  logic             pin_rst,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             reg_off_req,
  output logic             pin_hold,
  output logic             vreg5_en
);
  localparam int SW = NIRQ + 2;

  logic [SW-1:0] wake_s;
  logic          wake_irq, wake_bus, pin_rst_s;
  pmode_e        mode_q;
  logic          err_q, arm_q, hv_q;

  pms_sync #(.W(SW), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pin_rst, usb_act, irq_pend}),
    .q(wake_s)
  );

  assign wake_irq  = |wake_s[NIRQ-1:0];
  assign wake_bus  = wake_s[NIRQ];
  assign pin_rst_s = wake_s[NIRQ+1];

  pms_ctrl #(.CSW(CSW), .HF_SEL('0)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_src(clk_src),
    .wake_irq(wake_irq), .wake_bus(wake_bus), .pin_rst_s(pin_rst_s),
    .mode_q(mode_q), .err_q(err_q), .arm_q(arm_q), .hv_q(hv_q)
  );

  pms_view u_view (
    .mode_q(mode_q), .err_q(err_q), .arm_q(arm_q), .hv_q(hv_q),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .reg_off_req(reg_off_req), .pin_hold(pin_hold), .vreg5_en(vreg5_en)
  );
endmodule

// File: rtl/pms_chk.sv
module pms_chk
  import pms_pkg::*;
#(
  parameter int CSW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           core_clk_en,
  input logic           periph_clk_en,
  input logic           reg_off_req,
  input logic [CSW-1:0] clk_src,
  input logic           arm_q,
  input logic           err_q,
  input logic           pin_rst_s,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic           clr_bit
);
  // R2: the core clock never runs without the peripheral clock
  a_r2_core_needs_periph: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> periph_clk_en);

  // R6: shutdown is reached only with the arm bit set before
  a_r6_stop_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_off_req) |-> $past(arm_q));

  // R7: shutdown persists until a pin reset
  a_r7_shut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_off_req && !pin_rst_s) |=> reg_off_req);

  // R4: suspend entry only from the high-frequency source
  a_r4_susp_src: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(periph_clk_en) && !reg_off_req) |-> ($past(clk_src) == '0));

  // R4: error flag holds until cleared or reset
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !pin_rst_s && !(wr_en && wr_addr == A_OSC && clr_bit)) |=> err_q);
endmodule

bind pwr_mode_seq pms_chk #(.CSW(CSW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
  .reg_off_req(reg_off_req), .clk_src(clk_src),
  .arm_q(arm_q), .err_q(err_q), .pin_rst_s(pin_rst_s),
  .wr_en(wr_en), .wr_addr(wr_addr), .clr_bit(wr_data[7])
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int PERIOD = 10;
  localparam int NIRQ   = 4;

  logic clk = 1'b0;
  logic rst_n, wr_en, usb_act, pin_rst;
  logic [1:0] wr_addr, rd_addr, clk_src;
  logic [7:0] wr_data, rd_data;
  logic [NIRQ-1:0] irq_pend;
  logic core_clk_en, periph_clk_en, reg_off_req, pin_hold, vreg5_en;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  typedef struct {
    logic [4:0] outs;
    logic [7:0] rd;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.NIRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clk_src(clk_src), .irq_pend(irq_pend), .usb_act(usb_act),
    .pin_rst(pin_rst), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .reg_off_req(reg_off_req),
    .pin_hold(pin_hold), .vreg5_en(vreg5_en)
  );

  // outs order: core, periph, off, hold, vreg5
  task automatic expect_st(input logic [4:0] o, input logic [1:0] a,
                           input logic [7:0] d, input string r);
    exp_t e;
    rd_addr = a;
    e.outs = o; e.rd = d; e.req = r;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e = sb.pop_front();
      got = {core_clk_en, periph_clk_en, reg_off_req, pin_hold, vreg5_en};
      n_chk++;
      if (got !== e.outs || rd_data !== e.rd) begin
        n_err++;
        $display("FAIL %s: outs=%b rd=%h expected outs=%b rd=%h",
                 e.req, got, rd_data, e.outs, e.rd);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    clk_src = 2'b00; irq_pend = '0; usb_act = 1'b0; pin_rst = 1'b0;
    idle_cycles(3);
    rst_n = 1'b1;
    expect_st(5'b11001, 2'd0, 8'h00, "R1 reset power reg");
    idle_cycles(1);
    expect_st(5'b11001, 2'd2, 8'h02, "R1 reset regulator reg");
    idle_cycles(1);
    expect_st(5'b11001, 2'd1, 8'h00, "R1 reset osc reg");

    wr(2'd0, 8'h01);
    expect_st(5'b01001, 2'd0, 8'h01, "R2 idle entry");
    @(negedge clk); usb_act = 1'b1; @(negedge clk); usb_act = 1'b0;
    idle_cycles(3);
    expect_st(5'b01001, 2'd0, 8'h01, "R3 bus activity ignored in idle");
    irq_pend = 4'b0100;
    idle_cycles(2);
    expect_st(5'b01001, 2'd0, 8'h01, "R3 still idle at second edge");
    idle_cycles(1);
    expect_st(5'b11001, 2'd0, 8'h00, "R3 wake on third edge, bit cleared");
    irq_pend = '0;
    idle_cycles(3);

    clk_src = 2'b01;
    wr(2'd1, 8'h01);
    expect_st(5'b11001, 2'd1, 8'h80, "R4 suspend refused, error set");
    clk_src = 2'b00;
    wr(2'd1, 8'h80);
    expect_st(5'b11001, 2'd1, 8'h00, "R4 error cleared");
    wr(2'd1, 8'h01);
    expect_st(5'b00001, 2'd1, 8'h01, "R5 suspend entry");
    wr(2'd0, 8'h01);
    expect_st(5'b00001, 2'd0, 8'h00, "R9 idle write ignored in suspend");
    irq_pend = 4'b0001;
    idle_cycles(4);
    expect_st(5'b00001, 2'd1, 8'h01, "R5 interrupt ignored in suspend");
    irq_pend = '0;
    idle_cycles(2);
    @(negedge clk); usb_act = 1'b1; @(negedge clk); usb_act = 1'b0;
    expect_st(5'b00001, 2'd1, 8'h01, "R5 still suspended at first edge");
    idle_cycles(1);
    expect_st(5'b00001, 2'd1, 8'h01, "R5 still suspended at second edge");
    idle_cycles(1);
    expect_st(5'b11001, 2'd1, 8'h00, "R5 wake on third edge, bit cleared");
    idle_cycles(2);

    wr(2'd0, 8'h02);
    expect_st(5'b11001, 2'd2, 8'h02, "R6 stop without arm ignored");
    wr(2'd2, 8'h01);
    expect_st(5'b11000, 2'd2, 8'h01, "R8 5V regulator disabled");
    wr(2'd0, 8'h02);
    expect_st(5'b00110, 2'd2, 8'h01, "R6 shutdown entry, R8 regulator off");
    irq_pend = 4'b1000; usb_act = 1'b1;
    idle_cycles(4);
    expect_st(5'b00110, 2'd2, 8'h01, "R7 wake sources ignored in shutdown");
    irq_pend = '0; usb_act = 1'b0;
    pin_rst = 1'b1;
    idle_cycles(2);
    expect_st(5'b00110, 2'd2, 8'h01, "R7 still shut at second edge");
    idle_cycles(1);
    expect_st(5'b11001, 2'd2, 8'h02, "R7 pin reset restores normal");
    pin_rst = 1'b0;
    idle_cycles(4);

    wr(2'd2, 8'h03);
    wr(2'd0, 8'h02);
    expect_st(5'b00111, 2'd2, 8'h03, "R8 regulator kept on in shutdown");
    @(negedge clk);
    rst_n = 1'b0;
    expect_st(5'b11001, 2'd2, 8'h02, "R7 power-on reset leaves shutdown");
    @(negedge clk); rst_n = 1'b1;
    idle_cycles(3);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      done = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule